// File: doc/BRIEF.md
# Interrupt-Driven Transfer Activation Controller

This block sits between a set of interrupt sources and a data-transfer engine. For every source it keeps one enable bit. A request from a source whose bit is set is captured and later dispatched to the transfer engine as a start strobe. A request from a source whose bit is clear goes straight to the CPU interrupt output. Only one transfer is in flight at a time. When several enabled requests wait together, the lowest-numbered source goes first.

A shared 16-bit block counter counts the data units that remain. Each completed unit, reported by the transfer engine's done pulse, lowers the counter by one. A loaded value of zero stands for the full 65,536 units. At the end of a unit the serviced source's enable bit clears itself in two cases: the count has just reached zero, or the stop-after-one flag is set during the done cycle. When the bit clears this way, the request is also passed on to the CPU. In every other case the bit keeps its value. Software reads and writes the enable bits one byte at a time and loads the counter one byte at a time.

Top module: `xfer_act_ctrl`

## Requirements
- R1: After reset every enable bit is 0, the counter reads 0x0000, `busy` is 0, and neither `xfer_start` nor any `cpu_irq` bit is asserted.
- R2: A write with `bus_wr` high and `bus_idx` = k (k < 7) loads `bus_wdata` into enable byte k. Bit b of that byte is the enable of source 8k+b. `bus_rdata` returns enable byte `bus_idx` combinationally. An index of 7 reads 0x00.
- R3: `cnt_wr_lo` loads `bus_wdata` into counter bits 7:0 and `cnt_wr_hi` loads it into bits 15:8. A load takes priority over a decrement in the same cycle.
- R4: A one-cycle request pulse from an enabled source, sampled at edge t while the block is idle, produces a one-cycle `xfer_start` after edge t+1. At that time `xfer_src` holds the source number and `busy` is 1.
- R5: A request from a source whose enable bit is 0 never starts a transfer. It raises that source's `cpu_irq` bit for exactly one cycle, after the next clock edge.
- R6: When several enabled requests are pending, they are dispatched one at a time in ascending source order. No new `xfer_start` occurs until `xfer_done` has ended the current transfer.
- R7: Each `xfer_done` while busy lowers the counter by one, wrapping from 0x0000 to 0xFFFF. A loaded 0x0000 therefore allows 65,536 units.
- R8: If a done lowers the counter from 0x0001 to 0x0000, the serviced source's enable bit clears and its `cpu_irq` bit pulses for one cycle.
- R9: If `stop_after_one` is 1 during the done cycle, the serviced source's enable bit clears and its `cpu_irq` bit pulses, whatever the count.
- R10: If neither R8 nor R9 applies, the serviced source's enable bit is held and no `cpu_irq` pulse is made.
- R11: If a software write to an enable byte falls in the same cycle as a hardware clear of one of its bits, the hardware clear wins and that bit ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 56 | One-cycle request pulses, one per source |
| bus_wr | input | 1 | Enable-byte write strobe |
| bus_idx | input | 3 | Enable-byte index for read and write |
| bus_wdata | input | 8 | Write data for enable bytes and counter bytes |
| bus_rdata | output | 8 | Enable byte selected by `bus_idx` |
| cnt_wr_lo | input | 1 | Load counter low byte |
| cnt_wr_hi | input | 1 | Load counter high byte |
| stop_after_one | input | 1 | Clear the enable bit after the current unit |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| xfer_src | output | 6 | Source being serviced |
| xfer_done | input | 1 | Transfer engine reports one unit finished |
| busy | output | 1 | A transfer is in progress |
| cnt_value | output | 16 | Current counter value |
| cpu_irq | output | 56 | One-cycle per-source CPU interrupt pulses |

## Verification
The bench fires two enabled requests in the same cycle and expects them in ascending order. A design with reversed priority, or one that dispatches both at once, upsets the scoreboard order. It loads a count of 0x0000 and expects 0xFFFF with the enable held afterwards; a design that treats zero as "finished" would clear the bit and interrupt the CPU. It lets the counter run from one to zero, and separately sets the stop flag with a large count. In both cases a missing enable clear or a missing CPU pulse shows up. Finally, it writes an enable byte that sets a bit in the same cycle that bit's service ends; a design that lets the software write win would read the bit back as 1.

// File: rtl/xfer_act_ctrl.sv
module xfer_act_ctrl #(
  parameter int NREG  = 7,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREG*8-1:0]       irq_req,
  input  logic                    bus_wr,
  input  logic [2:0]              bus_idx,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  input  logic                    cnt_wr_lo,
  input  logic                    cnt_wr_hi,
  input  logic                    stop_after_one,
  output logic                    xfer_start,
  output logic [$clog2(NREG*8)-1:0] xfer_src,
  input  logic                    xfer_done,
  output logic                    busy,
  output logic [CNT_W-1:0]        cnt_value,
  output logic [NREG*8-1:0]       cpu_irq
);
  localparam int SRC = NREG * 8;
  localparam int SW  = $clog2(SRC);

  logic [SRC-1:0]   en, pend, cand, grant_mask, clr_mask, en_nxt;
  logic [CNT_W-1:0] cnt;
  logic [SW-1:0]    sel_idx;
  logic             sel_hit, unit_end, finish;

  assign cand      = pend & en;
  assign unit_end  = busy & xfer_done;
  assign finish    = unit_end & (stop_after_one | (cnt == CNT_W'(1)));
  assign clr_mask  = finish ? (SRC'(1) << xfer_src) : '0;
  assign grant_mask = (!busy && sel_hit) ? (SRC'(1) << sel_idx) : '0;
  assign cnt_value = cnt;

  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int i = SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        sel_hit = 1'b1;
        sel_idx = SW'(i);
      end
    end
  end

  always_comb begin
    en_nxt = en;
    for (int k = 0; k < NREG; k++)
      if (bus_wr && bus_idx == 3'(k)) en_nxt[8*k +: 8] = bus_wdata;
    en_nxt = en_nxt & ~clr_mask;
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int k = 0; k < NREG; k++)
      if (bus_idx == 3'(k)) bus_rdata = en[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en         <= '0;
      pend       <= '0;
      cnt        <= '0;
      busy       <= 1'b0;
      xfer_start <= 1'b0;
      xfer_src   <= '0;
      cpu_irq    <= '0;
    end else begin
      en      <= en_nxt;
      pend    <= (pend | (irq_req & en)) & en & ~grant_mask;
      cpu_irq <= (irq_req & ~en) | clr_mask;
      xfer_start <= 1'b0;
      if (cnt_wr_lo || cnt_wr_hi) begin
        if (cnt_wr_lo) cnt[7:0]       <= bus_wdata;
        if (cnt_wr_hi) cnt[CNT_W-1:8] <= bus_wdata[CNT_W-9:0];
      end else if (unit_end) begin
        cnt <= cnt - CNT_W'(1);
      end
      if (!busy) begin
        if (sel_hit) begin
          busy       <= 1'b1;
          xfer_start <= 1'b1;
          xfer_src   <= sel_idx;
        end
      end else if (xfer_done) begin
        busy <= 1'b0;
      end
    end
  end

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  // R6
  start_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> busy && !$past(busy));

  // R4
  start_src_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (($past(en) >> xfer_src) & SRC'(1)) == SRC'(1));

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && !cnt_wr_lo && !cnt_wr_hi) |=> cnt == $past(cnt) - CNT_W'(1));

  // R9
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && stop_after_one) |=> ((en >> $past(xfer_src)) & SRC'(1)) == '0);

  // R8
  empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && cnt == CNT_W'(1)) |=> ((cpu_irq >> $past(xfer_src)) & SRC'(1)) != '0);
endmodule

// File: tb/xfer_act_ctrl_test.sv
module xfer_act_ctrl_test;
  localparam int CLK_P = 10;
  localparam int KIND_START = 100;
  localparam int KIND_CPU   = 200;

  logic        clk = 0, rst_n = 0;
  logic [55:0] irq_req = '0;
  logic        bus_wr = 0, cnt_wr_lo = 0, cnt_wr_hi = 0, stop_after_one = 0, xfer_done = 0;
  logic [2:0]  bus_idx = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        xfer_start, busy;
  logic [5:0]  xfer_src;
  logic [15:0] cnt_value;
  logic [55:0] cpu_irq;

  int checks = 0, fails = 0;
  int exp_q[$];
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  xfer_act_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_wr(bus_wr), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi),
    .stop_after_one(stop_after_one), .xfer_start(xfer_start), .xfer_src(xfer_src),
    .xfer_done(xfer_done), .busy(busy), .cnt_value(cnt_value), .cpu_irq(cpu_irq));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic got(input int item);
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R4/R5/R6 actual=%0d expected=none", item);
    end else begin
      int e = exp_q.pop_front();
      if (e != item) begin
        fails++;
        $display("FAIL R4/R5/R6/R8/R9 actual=%0d expected=%0d", item, e);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (xfer_start) got(KIND_START + int'(xfer_src));
      for (int i = 0; i < 56; i++) if (cpu_irq[i]) got(KIND_CPU + i);
    end
  end

  task automatic wr_en(input int idx, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_idx = 3'(idx); bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic load_cnt(input logic [15:0] v);
    @(negedge clk); cnt_wr_lo = 1; bus_wdata = v[7:0];
    @(negedge clk); cnt_wr_lo = 0; cnt_wr_hi = 1; bus_wdata = v[15:8];
    @(negedge clk); cnt_wr_hi = 0;
  endtask

  task automatic rd_en(input int idx, output logic [7:0] d);
    bus_idx = 3'(idx); #1; d = bus_rdata;
  endtask

  task automatic fire(input logic [55:0] m);
    @(negedge clk); irq_req = m;
    @(negedge clk); irq_req = '0;
  endtask

  task automatic serve(input logic stop);
    do @(negedge clk); while (!xfer_start);
    check("R4 busy", int'(busy), 1);
    xfer_done = 1; stop_after_one = stop;
    @(negedge clk); xfer_done = 0; stop_after_one = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    // R1
    check("R1 cnt", int'(cnt_value), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 start", int'(xfer_start), 0);
    check("R1 cpu", int'(cpu_irq != 0), 0);
    for (int k = 0; k < 7; k++) begin rd_en(k, b); check("R1 en", int'(b), 0); end
    rst_n = 1;
    @(negedge clk);

    // R2
    wr_en(0, 8'h05);
    rd_en(0, b); check("R2 byte0", int'(b), 8'h05);
    wr_en(3, 8'hA5); rd_en(3, b); check("R2 byte3", int'(b), 8'hA5);
    wr_en(3, 8'h00); rd_en(3, b); check("R2 byte3 clr", int'(b), 0);
    rd_en(7, b); check("R2 idx7", int'(b), 0);

    // R3
    load_cnt(16'h0003); check("R3 load", int'(cnt_value), 3);

    // R4, R10
    exp_q.push_back(KIND_START + 2);
    fire(56'(1) << 2);
    serve(0);
    @(negedge clk);
    check("R7 dec", int'(cnt_value), 2);
    rd_en(0, b); check("R10 held", int'(b), 8'h05);

    // R6, R8
    exp_q.push_back(KIND_START + 0);
    exp_q.push_back(KIND_START + 2);
    exp_q.push_back(KIND_CPU + 2);
    fire((56'(1) << 2) | 56'(1));
    serve(0);
    serve(0);
    repeat (2) @(negedge clk);
    check("R8 cnt zero", int'(cnt_value), 0);
    rd_en(0, b); check("R8 en cleared", int'(b), 8'h01);

    // R5
    exp_q.push_back(KIND_CPU + 9);
    fire(56'(1) << 9);
    repeat (3) @(negedge clk);
    check("R5 idle", int'(busy), 0);

    // R9
    wr_en(6, 8'h80);
    load_cnt(16'h0010);
    exp_q.push_back(KIND_START + 55);
    exp_q.push_back(KIND_CPU + 55);
    fire(56'(1) << 55);
    serve(1);
    repeat (2) @(negedge clk);
    rd_en(6, b); check("R9 en cleared", int'(b), 0);
    check("R9 cnt", int'(cnt_value), 16'h000F);

    // R7 zero means full range
    load_cnt(16'h0000);
    exp_q.push_back(KIND_START + 0);
    fire(56'(1));
    serve(0);
    repeat (2) @(negedge clk);
    check("R7 wrap", int'(cnt_value), 16'hFFFF);
    rd_en(0, b); check("R7 en held", int'(b), 8'h01);

    // R11
    load_cnt(16'h0001);
    exp_q.push_back(KIND_START + 0);
    exp_q.push_back(KIND_CPU + 0);
    fire(56'(1));
    do @(negedge clk); while (!xfer_start);
    xfer_done = 1; bus_wr = 1; bus_idx = 3'd0; bus_wdata = 8'h01;
    @(negedge clk); xfer_done = 0; bus_wr = 0;
    repeat (2) @(negedge clk);
    rd_en(0, b); check("R11 hw wins", int'(b), 0);

    repeat (3) @(negedge clk);
    check("R4/R5 queue drained", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule